// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a lock-step lane group are enabled while the group runs through nested conditional code. A control sequencer issues one command per cycle: enter a conditional region with a per-lane predicate, switch to the opposite arm of the region, or leave the region. The block keeps a small stack of the masks that were active when each open region was entered. It also drives the current active-lane mask that gates the lane datapaths.

The opposite arm of a region is formed by inverting the current mask and restricting the result to the mask saved on entry. Lanes that were disabled before the region therefore stay disabled in both arms. A flag reports that no lane is enabled, so the sequencer can jump over an empty arm. Stack misuse, meaning overflow, underflow or switching arms outside any region, raises an error flag that stays set until reset. A misused command changes nothing else.

Top module: `simt_mask_stack`

## Requirements
- R1: After a synchronous active-low reset, the active mask is all ones, the empty-mask flag and the error flag are low, and the save stack holds no entries.
- R2: Command code 2'b01 (enter) with the stack not full saves the current mask on the stack, and the new mask becomes the current mask ANDed with the predicate input.
- R3: Command code 2'b10 (switch arm) with the stack not empty makes the new mask the bitwise inverse of the current mask ANDed with the most recently saved mask. The stack is not changed.
- R4: Command code 2'b11 (leave) with the stack not empty restores the most recently saved mask as the active mask and removes that entry.
- R5: The empty-mask output is high exactly when every bit of the active mask is zero. It changes in the same cycle as the mask.
- R6: An enter command while the stack already holds DEPTH entries sets the error flag and leaves the mask and the stack unchanged.
- R7: A leave or switch-arm command with an empty stack sets the error flag and leaves the mask unchanged.
- R8: Once set, the error flag stays high through any later commands until reset.
- R9: Command code 2'b00 (hold) changes nothing. The predicate input is ignored for every command other than enter.
- R10: Regions nest up to DEPTH levels, and leaving them restores the saved masks in last-in, first-out order.
- R11: A command presented before a rising clock edge takes effect at that edge. The outputs keep their old value until the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 2 | Command: 00 hold, 01 enter, 10 switch arm, 11 leave |
| pred | input | LANES | Per-lane branch predicate, used by enter only |
| active_mask | output | LANES | Current active-lane mask, bit i enables lane i |
| none_active | output | 1 | High when no lane is enabled |
| err_flag | output | 1 | Sticky stack-misuse flag |

## Verification
Every command changes the registered mask and error flag at the first rising edge after it is presented. The empty-mask flag follows from the mask with no extra delay, so all three results are due one edge after their stimulus. The bench drives each command on a falling edge and samples on the following falling edge, which lies exactly one rising edge later. For the latency requirement it also samples a quarter period after driving, before the edge, to confirm that the outputs have not yet moved. Expected masks come from a hand-computed vector table and from a bench-side stack model for deep nesting, overflow and underflow.

// File: rtl/smk_pkg.sv
// Shared command encoding for the divergence mask stack.
// Assumes a two-bit command field driven by the control sequencer.
package smk_pkg;

    typedef enum logic [1:0] {
        SMK_HOLD = 2'b00,
        SMK_PUSH = 2'b01,
        SMK_FLIP = 2'b10,
        SMK_POP  = 2'b11
    } smk_cmd_e;

endpackage

// File: rtl/smk_cmd_guard.sv
// Command guard: qualifies the incoming command against stack occupancy.
// Assumes exactly one command per cycle; illegal commands become no-ops
// and raise a fault strobe instead.
module smk_cmd_guard
    import smk_pkg::*;
(
    input  logic [1:0] cmd_i,
    input  logic       empty_i,
    input  logic       full_i,
    output logic       push_o,
    output logic       flip_o,
    output logic       pop_o,
    output logic       fault_o
);

    smk_cmd_e op;

    // Split the command into qualified strobes and a misuse strobe.
    always_comb begin
        op      = smk_cmd_e'(cmd_i);
        push_o  = 1'b0;
        flip_o  = 1'b0;
        pop_o   = 1'b0;
        fault_o = 1'b0;
        case (op)
            SMK_PUSH: begin
                push_o  = !full_i;
                fault_o = full_i;
            end
            SMK_FLIP: begin
                flip_o  = !empty_i;
                fault_o = empty_i;
            end
            SMK_POP: begin
                pop_o   = !empty_i;
                fault_o = empty_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/smk_save_stack.sv
// Save stack: holds the masks captured on region entry.
// Assumes push and pop are never asserted together and are already
// qualified against full and empty. top_o reads all ones when empty.
module smk_save_stack #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] wdata_i,
    output logic [LANES-1:0] top_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0]    sp_q;
    logic [LANES-1:0] slot_q [DEPTH];

    // Entry count register: one up on push, one down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_i) begin
            sp_q <= sp_q + PW'(1);
        end else if (pop_i) begin
            sp_q <= sp_q - PW'(1);
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            // Capture the outgoing mask into the slot at the current count.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[g] <= '1;
                end else if (push_i && (sp_q == PW'(g))) begin
                    slot_q[g] <= wdata_i;
                end
            end
        end
    endgenerate

    // Select the most recent entry for restore and arm switching.
    always_comb begin
        top_o = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == PW'(i + 1)) begin
                top_o = slot_q[i];
            end
        end
    end

    // Occupancy flags for the guard.
    always_comb begin
        empty_o = (sp_q == '0);
        full_o  = (sp_q == PW'(DEPTH));
    end

endmodule

// File: rtl/smk_lane_update.sv
// Lane update: per-lane next-mask selection from the qualified strobes.
// Assumes at most one strobe is high in a cycle.
module smk_lane_update #(
    parameter int LANES = 32
) (
    input  logic             push_i,
    input  logic             flip_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] cur_i,
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] top_i,
    output logic [LANES-1:0] next_o
);

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Choose this lane's enable for the next cycle.
            always_comb begin
                if (push_i) begin
                    next_o[l] = cur_i[l] & pred_i[l];
                end else if (flip_i) begin
                    next_o[l] = ~cur_i[l] & top_i[l];
                end else if (pop_i) begin
                    next_o[l] = top_i[l];
                end else begin
                    next_o[l] = cur_i[l];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/smk_idle_detect.sv
// Idle detect: flags a mask with no lane enabled, through a two-level
// grouped OR so the depth stays flat for wide lane groups.
// Assumes GROUP >= 1; a short last group is padded with zeros.
module smk_idle_detect #(
    parameter int LANES = 32,
    parameter int GROUP = 8
) (
    input  logic [LANES-1:0] mask_i,
    output logic             none_o
);

    localparam int NG  = (LANES + GROUP - 1) / GROUP;
    localparam int PAD = NG * GROUP;

    logic [PAD-1:0] padded;
    logic [NG-1:0]  any_g;

    // Widen the mask to a whole number of groups.
    always_comb begin
        padded = '0;
        padded[LANES-1:0] = mask_i;
    end

    genvar k;
    generate
        for (k = 0; k < NG; k++) begin : g_grp
            // First level: any lane enabled within this group.
            always_comb begin
                any_g[k] = |padded[k*GROUP +: GROUP];
            end
        end
    endgenerate

    // Second level: no group has an enabled lane.
    always_comb begin
        none_o = ~|any_g;
    end

endmodule

// File: rtl/simt_mask_stack.sv
// Divergence mask stack top: holds the active-lane mask for a lane group
// and a stack of masks saved on region entry. One command per cycle;
// results appear after the next rising edge. Misuse sets a sticky flag.
module simt_mask_stack #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] active_mask,
    output logic             none_active,
    output logic             err_flag
);

    logic             do_push;
    logic             do_flip;
    logic             do_pop;
    logic             misuse;
    logic             stk_empty;
    logic             stk_full;
    logic [LANES-1:0] stk_top;
    logic [LANES-1:0] mask_d;
    logic [LANES-1:0] mask_q;
    logic             err_q;

    smk_cmd_guard u_guard (
        .cmd_i   (cmd),
        .empty_i (stk_empty),
        .full_i  (stk_full),
        .push_o  (do_push),
        .flip_o  (do_flip),
        .pop_o   (do_pop),
        .fault_o (misuse)
    );

    smk_save_stack #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (do_push),
        .pop_i   (do_pop),
        .wdata_i (mask_q),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .full_o  (stk_full)
    );

    smk_lane_update #(
        .LANES (LANES)
    ) u_lanes (
        .push_i (do_push),
        .flip_i (do_flip),
        .pop_i  (do_pop),
        .cur_i  (mask_q),
        .pred_i (pred),
        .top_i  (stk_top),
        .next_o (mask_d)
    );

    smk_idle_detect #(
        .LANES (LANES),
        .GROUP (8)
    ) u_idle (
        .mask_i (mask_q),
        .none_o (none_active)
    );

    // Active mask register, all lanes enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end

    // Sticky misuse flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (misuse) begin
            err_q <= 1'b1;
        end
    end

    assign active_mask = mask_q;
    assign err_flag    = err_q;

endmodule

// File: rtl/simt_mask_stack_chk.sv
// Checker for the divergence mask stack, bound to every instance of the top.
// Observes ports plus the save-stack occupancy and top entry.
module simt_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd,
    input logic [LANES-1:0] pred,
    input logic [LANES-1:0] active_mask,
    input logic             none_active,
    input logic             err_flag,
    input logic             stk_empty,
    input logic             stk_full,
    input logic [LANES-1:0] stk_top
);

    AST_RESET_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (active_mask == '1 && !err_flag && stk_empty)); // R1

    AST_PUSH_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !stk_full) |=> (active_mask == $past(active_mask & pred))); // R2

    AST_PUSH_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !stk_full) |=> (stk_top == $past(active_mask) && !stk_empty)); // R2

    AST_FLIP_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && !stk_empty) |=> (active_mask == ($past(~active_mask) & $past(stk_top)))); // R3

    AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b11 && !stk_empty) |=> (active_mask == $past(stk_top))); // R4

    AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        none_active == (active_mask == '0)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && stk_full) |=> (err_flag && $stable(active_mask) && stk_full)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[1] && stk_empty) |=> (err_flag && $stable(active_mask) && stk_empty)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b00) |=> ($stable(active_mask) && $stable(stk_top))); // R9

endmodule

bind simt_mask_stack simt_mask_stack_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .pred        (pred),
    .active_mask (active_mask),
    .none_active (none_active),
    .err_flag    (err_flag),
    .stk_empty   (stk_empty),
    .stk_full    (stk_full),
    .stk_top     (stk_top)
);

// File: tb/simt_mask_stack_tb.sv
module simt_mask_stack_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 32;
    localparam int DEPTH      = 8;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [1:0]  c;
        logic [31:0] p;
        logic [31:0] m;
        logic        z;
        logic        e;
    } vec_t;

    // Nested if/else walk; expected values worked out by hand from R2-R5, R7, R9.
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'b01, 32'h0000FFFF, 32'h0000FFFF, 1'b0, 1'b0},
        '{2'b01, 32'h00FF00FF, 32'h000000FF, 1'b0, 1'b0},
        '{2'b10, 32'hFFFFFFFF, 32'h0000FF00, 1'b0, 1'b0},
        '{2'b01, 32'hF0F0F0F0, 32'h0000F000, 1'b0, 1'b0},
        '{2'b10, 32'h00000000, 32'h00000F00, 1'b0, 1'b0},
        '{2'b11, 32'hAAAAAAAA, 32'h0000FF00, 1'b0, 1'b0},
        '{2'b11, 32'h55555555, 32'h0000FFFF, 1'b0, 1'b0},
        '{2'b10, 32'h00000000, 32'hFFFF0000, 1'b0, 1'b0},
        '{2'b00, 32'h12345678, 32'hFFFF0000, 1'b0, 1'b0},
        '{2'b01, 32'h0000FFFF, 32'h00000000, 1'b1, 1'b0},
        '{2'b10, 32'h0F0F0F0F, 32'hFFFF0000, 1'b0, 1'b0},
        '{2'b11, 32'h00000000, 32'hFFFF0000, 1'b0, 1'b0},
        '{2'b11, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0},
        '{2'b11, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b1}
    };

    logic             clk;
    logic             rst_n;
    logic [1:0]       cmd;
    logic [LANES-1:0] pred;
    logic [LANES-1:0] active_mask;
    logic             none_active;
    logic             err_flag;

    int applied;
    int miscompares;

    logic [LANES-1:0] m_stk [DEPTH];
    int               m_sp;
    logic [LANES-1:0] m_mask;
    logic             m_err;

    simt_mask_stack #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .pred        (pred),
        .active_mask (active_mask),
        .none_active (none_active),
        .err_flag    (err_flag)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [LANES-1:0] am,
                         input logic az, input logic ae,
                         input logic [LANES-1:0] em, input logic ez, input logic ee);
        applied++;
        if (am !== em || az !== ez || ae !== ee) begin
            miscompares++;
            $display("FAIL %s actual mask=%h none=%b err=%b expected mask=%h none=%b err=%b",
                     req, am, az, ae, em, ez, ee);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd   = 2'b00;
        pred  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        m_sp   = 0;
        m_mask = '1;
        m_err  = 1'b0;
    endtask

    // Apply one command through the bench model and compare a cycle later.
    task automatic step(input logic [1:0] c, input logic [LANES-1:0] p, input string req);
        cmd  = c;
        pred = p;
        case (c)
            2'b01: if (m_sp == DEPTH) m_err = 1'b1;
                   else begin m_stk[m_sp] = m_mask; m_sp++; m_mask = m_mask & p; end
            2'b10: if (m_sp == 0) m_err = 1'b1;
                   else m_mask = ~m_mask & m_stk[m_sp-1];
            2'b11: if (m_sp == 0) m_err = 1'b1;
                   else begin m_sp--; m_mask = m_stk[m_sp]; end
            default: ;
        endcase
        @(negedge clk);
        cmd = 2'b00;
        check(req, active_mask, none_active, err_flag, m_mask, (m_mask == '0), m_err);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        applied     = 0;
        miscompares = 0;
        do_reset();

        // R1: reset state
        check("R1", active_mask, none_active, err_flag, '1, 1'b0, 1'b0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            cmd  = TBL[i].c;
            pred = TBL[i].p;
            @(negedge clk);
            cmd = 2'b00;
            check((i == NV - 1) ? "R7" : (TBL[i].z ? "R5" : tag_of(TBL[i].c)),
                  active_mask, none_active, err_flag, TBL[i].m, TBL[i].z, TBL[i].e);
        end

        // R8: err stays set through legal commands
        cmd = 2'b01; pred = 32'h0F0F0F0F;
        @(negedge clk);
        cmd = 2'b00;
        check("R8", active_mask, none_active, err_flag, 32'h0F0F0F0F, 1'b0, 1'b1);

        // R1: reset clears state; pop afterwards proves the stack is empty
        do_reset();
        check("R1", active_mask, none_active, err_flag, '1, 1'b0, 1'b0);
        step(2'b11, '0, "R1");

        // R7: switch arm with empty stack
        do_reset();
        step(2'b10, 32'h0000FFFF, "R7");

        // R10: nest DEPTH levels, then R6 overflow, then unwind LIFO
        do_reset();
        for (int d = 0; d < DEPTH; d++) begin
            step(2'b01, ~(32'h1 << (d * 3)), "R10");
        end
        step(2'b01, 32'h00000000, "R6");
        for (int d = 0; d < DEPTH; d++) begin
            step(2'b11, 32'hFFFFFFFF, "R10");
        end
        step(2'b11, '0, "R7");

        // R9: predicate ignored on switch arm
        do_reset();
        step(2'b01, 32'hFF00FF00, "R2");
        step(2'b10, 32'h00000000, "R9");
        step(2'b10, 32'hFFFFFFFF, "R3");
        step(2'b00, 32'h00000000, "R9");

        // R11: outputs hold before the edge, change at it
        cmd  = 2'b01;
        pred = 32'h0000000F;
        #(CLK_PERIOD / 4);
        check("R11", active_mask, none_active, err_flag, 32'hFF00FF00, 1'b0, 1'b0);
        @(negedge clk);
        cmd = 2'b00;
        check("R11", active_mask, none_active, err_flag, 32'h00000000, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule